// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block supervises software liveness through one write-only command port that carries an enable bit and a 3-bit key. After reset the watchdog is idle. A write with the enable bit set starts the first timeout and stores the written key. From then on, software must keep servicing it. A restart is a write with enable 1 whose key is the bitwise inverse of the stored key. A stop is the same write with enable 0. Any other key value only replaces the stored key. Correct servicing therefore flips all three key bits on every restart.

Expiry happens in two stages. When the first timeout runs out, the block emits a one-cycle non-maskable interrupt pulse and starts a shorter grace interval. If the grace interval also runs out without a valid restart or stop, the chip-reset output rises. It stays high until the block's own asynchronous reset returns it to the idle state. Both intervals are parameters counted in clock cycles. Their defaults match 0.1 s and 3.3 ms at a 50 MHz clock.

Top module: `wdg_keyed_watchdog`

## Requirements
- R1: While rst_ni is low and after it is released, the watchdog is idle with nmi_o and chip_rst_o both 0.
- R2: In the idle state, a write with wr_enable_i = 0 has no effect: no interrupt and no reset follow, whatever the key.
- R3: In the idle state, a write with wr_enable_i = 1 starts the watchdog and stores wr_key_i. If no service follows, nmi_o is high for exactly one cycle. That cycle comes TIMEOUT1_CYCLES clock edges after the edge that captured the write.
- R4: With no service after the interrupt, chip_rst_o rises TIMEOUT2_CYCLES edges after the interrupt edge. It then stays high until rst_ni is asserted.
- R5: While running, a write with wr_enable_i = 0 and wr_key_i equal to the bitwise NOT of the stored key stops the watchdog. No interrupt or reset follows.
- R6: While running, a write with wr_enable_i = 1 and wr_key_i equal to the bitwise NOT of the stored key restarts the first timeout from zero and stores wr_key_i.
- R7: While running, a write whose key is not the inverse of the stored key replaces the stored key with wr_key_i, for either enable value. It does not reload the running interval.
- R8: A valid restart or stop during the grace interval cancels the pending reset. A restart begins a fresh first timeout.
- R9: A valid restart or stop captured on the same edge as an expiry takes priority. No interrupt or reset is raised on that edge.
- R10: Once chip_rst_o is high, all writes are ignored, and nmi_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Command write strobe, one cycle per write |
| wr_enable_i | input | 1 | Enable bit of the written command |
| wr_key_i | input | KEY_W | Key field of the written command |
| nmi_o | output | 1 | One-cycle non-maskable interrupt pulse at first expiry |
| chip_rst_o | output | 1 | Chip reset request, held once raised |

## Verification
On every cycle, the assertions check these behaviours:
- the interrupt is a single pulse;
- the fired state is sticky;
- a stop always lands in idle, and an idle enable-0 write leaves the block idle;
- a non-matching key never reloads the counter;
- the stored key changes as the write rules demand;
- a grace-stage restart always blocks the reset;
- the interrupt is never raised while the reset is held.

The exact distance in cycles from a write to the interrupt, and from the interrupt to the reset, can only be shown by the bench's scenarios. The same goes for service landing on every possible cycle, including the two expiry edges. Whether a key change takes effect is also a scenario-only check: the bench shows it through which later write acts as a valid restart, across all key pairs.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    WD_IDLE   = 2'd0,
    WD_STAGE1 = 2'd1,
    WD_STAGE2 = 2'd2,
    WD_FIRED  = 2'd3
  } wd_state_e;

  typedef struct packed {
    logic start;
    logic restart;
    logic stop;
    logic rekey;
  } wd_cmd_t;

endpackage

// File: rtl/wdg_key_ctrl.sv
module wdg_key_ctrl
  import wdg_pkg::*;
#(
  parameter int unsigned KEY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic             wr_enable_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  wd_state_e        state_i,
  output wd_cmd_t          cmd_o
);

  logic [KEY_W-1:0] key_q;
  logic             live;
  logic             inv_match;

  assign live      = (state_i == WD_STAGE1) || (state_i == WD_STAGE2);
  assign inv_match = (wr_key_i == ~key_q);

  always_comb begin
    cmd_o = '0;
    if (wr_valid_i) begin
      if (state_i == WD_IDLE) begin
        cmd_o.start = wr_enable_i;
      end else if (live) begin
        if (inv_match) begin
          cmd_o.restart = wr_enable_i;
          cmd_o.stop    = !wr_enable_i;
        end else begin
          cmd_o.rekey = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
    end else if (cmd_o.start || cmd_o.restart || cmd_o.rekey) begin
      key_q <= wr_key_i;
    end
  end

  assert_rekey_stores_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && wr_valid_i && (wr_key_i != ~key_q)) |=> (key_q == $past(wr_key_i)));

  assert_restart_flips_key_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && wr_valid_i && wr_enable_i && (wr_key_i == ~key_q)) |=> (key_q == ~$past(key_q)));

endmodule

// File: rtl/wdg_stage_timer.sv
module wdg_stage_timer
  import wdg_pkg::*;
#(
  parameter int unsigned TIMEOUT1_CYCLES = 5_000_000,
  parameter int unsigned TIMEOUT2_CYCLES = 165_000
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  wd_cmd_t   cmd_i,
  output wd_state_e state_o,
  output logic      nmi_o,
  output logic      chip_rst_o
);

  localparam int unsigned MAX_T = (TIMEOUT1_CYCLES > TIMEOUT2_CYCLES) ? TIMEOUT1_CYCLES : TIMEOUT2_CYCLES;
  localparam int unsigned CNT_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;
  localparam logic [CNT_W-1:0] LAST1 = CNT_W'(TIMEOUT1_CYCLES - 1);
  localparam logic [CNT_W-1:0] LAST2 = CNT_W'(TIMEOUT2_CYCLES - 1);

  wd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             nmi_q, nmi_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    nmi_d   = 1'b0;
    unique case (state_q)
      WD_IDLE: begin
        if (cmd_i.start) begin
          state_d = WD_STAGE1;
          cnt_d   = '0;
        end
      end
      WD_STAGE1: begin
        if (cmd_i.stop) begin
          state_d = WD_IDLE;
          cnt_d   = '0;
        end else if (cmd_i.restart) begin
          cnt_d = '0;
        end else if (cnt_q == LAST1) begin
          state_d = WD_STAGE2;
          cnt_d   = '0;
          nmi_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      WD_STAGE2: begin
        if (cmd_i.stop) begin
          state_d = WD_IDLE;
          cnt_d   = '0;
        end else if (cmd_i.restart) begin
          state_d = WD_STAGE1;
          cnt_d   = '0;
        end else if (cnt_q == LAST2) begin
          state_d = WD_FIRED;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      WD_FIRED: begin
        state_d = WD_FIRED;
      end
      default: begin
        state_d = WD_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
      nmi_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      nmi_q   <= nmi_d;
    end
  end

  assign state_o    = state_q;
  assign nmi_o      = nmi_q;
  assign chip_rst_o = (state_q == WD_FIRED);

  assert_nmi_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_q |=> !nmi_q);

  assert_fired_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WD_FIRED) |=> (state_q == WD_FIRED));

  assert_fire_from_grace_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chip_rst_o) |-> ($past(state_q) == WD_STAGE2));

  assert_stop_lands_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.stop |=> (state_q == WD_IDLE));

  assert_rekey_no_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == WD_STAGE1) && cmd_i.rekey && (cnt_q != LAST1)) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_service_beats_fire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == WD_STAGE2) && (cmd_i.restart || cmd_i.stop)) |=> !chip_rst_o);

  assert_quiet_when_fired_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |-> !nmi_o);

endmodule

// File: rtl/wdg_keyed_watchdog.sv
module wdg_keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned TIMEOUT1_CYCLES = 5_000_000,
  parameter int unsigned TIMEOUT2_CYCLES = 165_000,
  parameter int unsigned KEY_W           = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic             wr_enable_i,
  input  logic [KEY_W-1:0] wr_key_i,
  output logic             nmi_o,
  output logic             chip_rst_o
);

  wd_state_e state;
  wd_cmd_t   cmd;

  wdg_key_ctrl #(
    .KEY_W(KEY_W)
  ) u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_enable_i(wr_enable_i),
    .wr_key_i   (wr_key_i),
    .state_i    (state),
    .cmd_o      (cmd)
  );

  wdg_stage_timer #(
    .TIMEOUT1_CYCLES(TIMEOUT1_CYCLES),
    .TIMEOUT2_CYCLES(TIMEOUT2_CYCLES)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .state_o   (state),
    .nmi_o     (nmi_o),
    .chip_rst_o(chip_rst_o)
  );

  assert_idle_ignores_disable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == WD_IDLE) && wr_valid_i && !wr_enable_i) |=> (state == WD_IDLE));

  assert_idle_is_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == WD_IDLE) |-> (!chip_rst_o));

endmodule

// File: tb/wdg_keyed_watchdog_tb.sv
`timescale 1ns/1ps
module wdg_keyed_watchdog_tb;

  localparam int T1 = 6;
  localparam int T2 = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_enable = 1'b0;
  logic [2:0] wr_key = '0;
  logic       nmi, chip_rst;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    exp_nmi = -1;
  int    exp_rst = -1;
  int    last_edge = 0;
  bit    b_run = 1'b0;
  logic [2:0] b_key = '0;
  bit    mon_on = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdg_keyed_watchdog #(
    .TIMEOUT1_CYCLES(T1),
    .TIMEOUT2_CYCLES(T2),
    .KEY_W(3)
  ) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_valid_i (wr_valid),
    .wr_enable_i(wr_enable),
    .wr_key_i   (wr_key),
    .nmi_o      (nmi),
    .chip_rst_o (chip_rst)
  );

  // per-cycle comparison against arithmetic expectations
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      checks++;
      if (nmi !== ((exp_nmi >= 0) && (cyc == exp_nmi))) begin
        fails++;
        $display("FAIL %s nmi_o cyc %0d: got %0b exp %0b", cur_req, cyc, nmi,
                 (exp_nmi >= 0) && (cyc == exp_nmi));
      end
      checks++;
      if (chip_rst !== ((exp_rst >= 0) && (cyc >= exp_rst))) begin
        fails++;
        $display("FAIL %s chip_rst_o cyc %0d: got %0b exp %0b", cur_req, cyc, chip_rst,
                 (exp_rst >= 0) && (cyc >= exp_rst));
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    exp_nmi = -1;
    exp_rst = -1;
    b_run   = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  // caller stands at a negedge; write is captured on the next posedge
  task automatic wr(input logic en, input logic [2:0] k);
    int ed;
    bit fired;
    ed    = cyc + 1;
    fired = (exp_rst >= 0) && (ed > exp_rst);
    if (!fired) begin
      if (!b_run) begin
        if (en) begin
          b_run = 1'b1; b_key = k;
          exp_nmi = ed + T1; exp_rst = ed + T1 + T2;
        end
      end else if (k == ~b_key) begin
        if (en) begin
          b_key = k;
          exp_nmi = ed + T1; exp_rst = ed + T1 + T2;
        end else begin
          b_run = 1'b0; exp_nmi = -1; exp_rst = -1;
        end
      end else begin
        b_key = k;
      end
    end
    last_edge = ed;
    wr_valid = 1'b1; wr_enable = en; wr_key = k;
    @(negedge clk);
    wr_valid = 1'b0; wr_enable = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired at cyc %0d: got hang exp completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int s;
    int c;
    @(negedge clk);
    mon_on = 1'b1;
    cur_req = "R1";
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(3);

    // R2: disable writes while idle
    cur_req = "R2";
    for (int k = 0; k < 8; k++) wr(1'b0, 3'(k));
    wait_cyc(T1 + T2 + 3);

    // R3/R4/R10: unattended expiry, then writes while fired
    for (int k = 0; k < 8; k++) begin
      do_reset();
      cur_req = "R3";
      wr(1'b1, 3'(k));
      s = last_edge;
      wait_to(s + T1 + 1);
      cur_req = "R4";
      wait_to(s + T1 + T2 + 2);
      cur_req = "R10";
      wr(1'b1, ~3'(k));
      wr(1'b0, ~3'(k));
      wr(1'b1, 3'(k));
      wait_cyc(4);
    end

    // R6/R8/R9/R10: service landing on every cycle around both expiries
    for (int d = 0; d <= T1 + T2 + 1; d++) begin
      do_reset();
      cur_req = "R3";
      wr(1'b1, 3'd5);
      s = last_edge;
      c = s + d + 1;
      if (c < s + T1) cur_req = "R6";
      else if (c == s + T1) cur_req = "R9";
      else if (c < s + T1 + T2) cur_req = "R8";
      else if (c == s + T1 + T2) cur_req = "R9";
      else cur_req = "R10";
      wait_to(s + d);
      wr(1'b1, 3'd2);
      wait_cyc(T1 + T2 + 3);
    end

    // stop in grace stage
    do_reset();
    cur_req = "R8";
    wr(1'b1, 3'd0);
    s = last_edge;
    wait_to(s + T1 + 1);
    wr(1'b0, 3'd7);
    wait_cyc(T1 + T2 + 3);

    // R5/R6/R7: every stored key against every written key and enable
    for (int k = 0; k < 8; k++) begin
      for (int w = 0; w < 8; w++) begin
        for (int e = 0; e < 2; e++) begin
          do_reset();
          cur_req = "R3";
          wr(1'b1, 3'(k));
          wait_cyc(2);
          if (3'(w) == ~3'(k)) cur_req = (e == 1) ? "R6" : "R5";
          else cur_req = "R7";
          wr(e[0], 3'(w));
          wr(1'b1, ~3'(w));
          wait_cyc(T1 + T2 + 2);
        end
      end
    end

    mon_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule